// File: doc/BRIEF.md
# Multiplexed LED Matrix Driver

This block lights a matrix of 7 rows by 8 columns of LEDs by scanning it one row at a time, and it also drives two single LEDs (a message lamp and a speaker lamp) that are not part of the matrix. Each LED has a 4-bit rate code. The code selects off, steady on, or one of fourteen blink patterns. All patterns are derived from one shared timebase that advances on a 32.768 kHz strobe, so every LED with the same code blinks in step with every other.

Rows are lit in order from 0 to 6. Each row is preceded by a short dark interval so that the column lines can settle. After row 6 the driver turns the matrix off and hands the time to a key scanner through a request/done handshake. When the scanner reports that it is done, drive restarts at row 0. Software loads the codes two at a time through a simple write port. A new code becomes visible only when a row starts, so no row ever shows a pattern that changes while it is lit.

Top module: `lmx_driver`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every rate code is 0, `row_n` is all ones, `col` is 0, and `pwr_en`, `msg_led`, `spk_led` and `scan_req` are low. The first row lit after reset is row 0, after a dark interval.
- R2: At most one bit of `row_n` is low at any time. While row r is lit, bit r of `row_n` is 0 and every other bit is 1. While no row is lit, `row_n` is all ones.
- R3: While row r is lit, `col[c]` shows the pattern state of LED index r*8+c. While no row is lit, `col` is 0.
- R4: `pwr_en` is high exactly while a row is lit. A row stays lit for 48 `slow_tick` strobes. Between two consecutive rows there is a dark interval of 2 strobes, during which `pwr_en` is low.
- R5: Rows are lit in the order 0, 1, ..., 6. After row 6, `scan_req` rises and stays high, with the matrix dark, until `scan_done` is sampled high. Then a 2-strobe dark interval follows, and row 0 is lit.
- R6: A write with `wr_en` high to address n (0 to 27) sets the code of LED 2n to `wr_data[3:0]` and the code of LED 2n+1 to `wr_data[7:4]`. LED index i sits at row i/8, column i%8. Address 28 sets the message lamp code from bits [3:0] and the speaker lamp code from bits [7:4]. Addresses 29 to 31 change nothing.
- R7: Code 0 is off and code 1 is steady on. A code k from 2 to 8 is on when bit k+6 of the timebase is 1. A code k from 9 to 15 is on when bit k-1 of the timebase is 0. The timebase is a 15-bit count of `slow_tick` strobes since reset, starting at 0.
- R8: The column pattern of a row, and the levels of `msg_led` and `spk_led`, are computed at the clock edge on which that row becomes lit. They use the codes and the timebase as they stood before that edge, and they hold until the next row is lit.
- R9: `scan_done` has no effect while `scan_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| wr_en | input | 1 | Rate register write enable |
| wr_addr | input | 5 | Rate register address |
| wr_data | input | 8 | Two rate codes: [3:0] even LED, [7:4] odd LED |
| scan_done | input | 1 | Key scanner finished its sample |
| row_n | output | 7 | Row selects, active low |
| col | output | 8 | Column drives, active high |
| pwr_en | output | 1 | Matrix power enable |
| msg_led | output | 1 | Message lamp output |
| spk_led | output | 1 | Speaker lamp output |
| scan_req | output | 1 | Matrix is dark and the key scanner may sample |

## Verification
Every output comes straight from registers. A `slow_tick` strobe or a `scan_done` sampled at one rising edge therefore shows on `row_n`, `pwr_en` and `scan_req` right after that same edge. A write reaches `col` and the two lamps only at the later edge on which a row becomes lit. The bench drives its inputs on falling edges. It advances a behavioural model on each rising edge, using the input values just sampled, and compares every output against the model on the following falling edge. Directed checks wait for the edge that starts a row, such as the row-0 start after a scan, before they sample the effect of a write.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

    localparam int CODE_W   = 4;
    localparam int PAIR_W   = 2 * CODE_W;
    localparam int TB_W     = 15;
    localparam int TAP_LO   = 8;

    typedef logic [CODE_W-1:0] rate_code_t;

    localparam rate_code_t CODE_OFF      = 4'd0;
    localparam rate_code_t CODE_ON       = 4'd1;
    localparam rate_code_t CODE_LAST_POS = 4'd8;

    typedef enum logic [1:0] {
        PH_BLANK = 2'd0,
        PH_LIT   = 2'd1,
        PH_SCAN  = 2'd2
    } drv_phase_e;

    typedef struct packed {
        rate_code_t hi;
        rate_code_t lo;
    } rate_pair_t;

    // Pattern state of one LED for a given code and timebase value.
    function automatic logic flash_on(input rate_code_t code, input logic [TB_W-1:0] tb);
        int tap;
        if (code == CODE_OFF) return 1'b0;
        if (code == CODE_ON)  return 1'b1;
        if (code <= CODE_LAST_POS) begin
            tap = TAP_LO + int'(code) - 2;
            return tb[tap];
        end
        tap = TAP_LO + int'(code) - 9;
        return ~tb[tap];
    endfunction

endpackage

// File: rtl/lmx_timebase.sv
module lmx_timebase
    import lmx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    output logic [TB_W-1:0] tb
);

    always_ff @(posedge clk) begin
        if (rst)       tb <= '0;
        else if (tick) tb <= tb + TB_W'(1);
    end

endmodule

// File: rtl/lmx_rate_bank.sv
module lmx_rate_bank
    import lmx_pkg::*;
#(
    parameter int NLED = 56,
    localparam int NREG = NLED / 2 + 1,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [PAIR_W-1:0]      wr_data,
    output logic [NLED*CODE_W-1:0] led_codes,
    output logic [2*CODE_W-1:0]    dir_codes
);

    rate_pair_t bank [NREG];
    logic       addr_ok;

    assign addr_ok = int'(wr_addr) < NREG;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) bank[i] <= '0;
        end else if (wr_en && addr_ok) begin
            bank[wr_addr] <= rate_pair_t'(wr_data);
        end
    end

    for (genvar r = 0; r < NLED / 2; r++) begin : g_map
        assign led_codes[(2*r)*CODE_W   +: CODE_W] = bank[r].lo;
        assign led_codes[(2*r+1)*CODE_W +: CODE_W] = bank[r].hi;
    end

    assign dir_codes = {bank[NREG-1].hi, bank[NREG-1].lo};

endmodule

// File: rtl/lmx_sequencer.sv
module lmx_sequencer
    import lmx_pkg::*;
#(
    parameter int ROWS        = 7,
    parameter int ROW_TICKS   = 48,
    parameter int BLANK_TICKS = 2,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int CNT_MAX = (ROW_TICKS > BLANK_TICKS) ? ROW_TICKS : BLANK_TICKS,
    localparam int CNT_W   = $clog2(CNT_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             scan_done,
    output drv_phase_e       phase,
    output logic [ROW_W-1:0] row,
    output logic             row_start
);

    drv_phase_e       phase_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] cnt_q;
    logic             blank_end;
    logic             lit_end;
    logic             last_row;

    assign blank_end = (phase_q == PH_BLANK) && tick && (cnt_q == CNT_W'(BLANK_TICKS - 1));
    assign lit_end   = (phase_q == PH_LIT)   && tick && (cnt_q == CNT_W'(ROW_TICKS - 1));
    assign last_row  = (row_q == ROW_W'(ROWS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_BLANK;
            row_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_BLANK: begin
                    if (blank_end) begin
                        phase_q <= PH_LIT;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        cnt_q   <= cnt_q + CNT_W'(1);
                    end
                end
                PH_LIT: begin
                    if (lit_end) begin
                        cnt_q <= '0;
                        if (last_row) begin
                            phase_q <= PH_SCAN;
                        end else begin
                            phase_q <= PH_BLANK;
                            row_q   <= row_q + ROW_W'(1);
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_SCAN: begin
                    if (scan_done) begin
                        phase_q <= PH_BLANK;
                        row_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    phase_q <= PH_BLANK;
                    row_q   <= '0;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign phase     = phase_q;
    assign row       = row_q;
    assign row_start = blank_end;

endmodule

// File: rtl/lmx_row_builder.sv
module lmx_row_builder
    import lmx_pkg::*;
#(
    parameter int ROWS = 7,
    parameter int COLS = 8,
    localparam int NLED  = ROWS * COLS,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic [NLED*CODE_W-1:0] led_codes,
    input  logic [ROW_W-1:0]       row,
    input  logic [TB_W-1:0]        tb,
    output logic [COLS-1:0]        col_next
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        rate_code_t code_c;
        always_comb begin
            code_c      = led_codes[(int'(row) * COLS + c) * CODE_W +: CODE_W];
            col_next[c] = flash_on(code_c, tb);
        end
    end

endmodule

// File: rtl/lmx_driver.sv
module lmx_driver
    import lmx_pkg::*;
#(
    parameter int ROWS        = 7,
    parameter int COLS        = 8,
    parameter int ROW_TICKS   = 48,
    parameter int BLANK_TICKS = 2,
    localparam int NLED  = ROWS * COLS,
    localparam int NREG  = NLED / 2 + 1,
    localparam int AW    = $clog2(NREG),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [PAIR_W-1:0] wr_data,
    input  logic              scan_done,
    output logic [ROWS-1:0]   row_n,
    output logic [COLS-1:0]   col,
    output logic              pwr_en,
    output logic              msg_led,
    output logic              spk_led,
    output logic              scan_req
);

    logic [TB_W-1:0]        tb;
    logic [NLED*CODE_W-1:0] led_codes;
    logic [2*CODE_W-1:0]    dir_codes;
    drv_phase_e             phase;
    logic [ROW_W-1:0]       row;
    logic                   row_start;
    logic [COLS-1:0]        col_next;
    logic [COLS-1:0]        col_q;
    logic                   msg_q;
    logic                   spk_q;
    logic                   lit;

    lmx_timebase u_tb (
        .clk  (clk),
        .rst  (rst),
        .tick (slow_tick),
        .tb   (tb)
    );

    lmx_rate_bank #(.NLED(NLED)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .led_codes (led_codes),
        .dir_codes (dir_codes)
    );

    lmx_sequencer #(
        .ROWS        (ROWS),
        .ROW_TICKS   (ROW_TICKS),
        .BLANK_TICKS (BLANK_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (slow_tick),
        .scan_done (scan_done),
        .phase     (phase),
        .row       (row),
        .row_start (row_start)
    );

    lmx_row_builder #(.ROWS(ROWS), .COLS(COLS)) u_build (
        .led_codes (led_codes),
        .row       (row),
        .tb        (tb),
        .col_next  (col_next)
    );

    // Patterns are frozen at the edge that lights a row.
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            msg_q <= 1'b0;
            spk_q <= 1'b0;
        end else if (row_start) begin
            col_q <= col_next;
            msg_q <= flash_on(dir_codes[CODE_W-1:0], tb);
            spk_q <= flash_on(dir_codes[2*CODE_W-1:CODE_W], tb);
        end
    end

    assign lit      = (phase == PH_LIT);
    assign row_n    = lit ? ~(ROWS'(1) << row) : '1;
    assign col      = lit ? col_q : '0;
    assign pwr_en   = lit;
    assign scan_req = (phase == PH_SCAN);
    assign msg_led  = msg_q;
    assign spk_led  = spk_q;

endmodule

// File: rtl/lmx_driver_chk.sv
module lmx_driver_chk #(
    parameter int ROWS = 7,
    parameter int COLS = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [ROWS-1:0] row_n,
    input logic [COLS-1:0] col,
    input logic            pwr_en,
    input logic            msg_led,
    input logic            spk_led,
    input logic            scan_req
);

    // R2
    one_row_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~row_n));

    // R4
    lit_has_row_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_en |-> ($countones(~row_n) == 1));

    // R3
    dark_col_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> (col == '0));

    // R4
    row_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && $past(pwr_en)) |-> $stable(row_n));

    // R8
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && $past(pwr_en)) |-> $stable(col));

    // R8
    lamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(pwr_en) |-> $stable({msg_led, spk_led}));

    // R5
    scan_dark_chk: assert property (@(posedge clk) disable iff (rst)
        scan_req |-> !pwr_en);

    // R5
    scan_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_req) |-> ($past(row_n) == ~(ROWS'(1) << (ROWS - 1))));

endmodule

bind lmx_driver lmx_driver_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .row_n    (row_n),
    .col      (col),
    .pwr_en   (pwr_en),
    .msg_led  (msg_led),
    .spk_led  (spk_led),
    .scan_req (scan_req)
);

// File: tb/sim_lmx_driver.sv
module sim_lmx_driver;

    localparam int NCODE = 58;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       scan_done = 1'b0;
    logic [6:0] row_n;
    logic [7:0] col;
    logic       pwr_en, msg_led, spk_led, scan_req;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    lmx_driver u0 (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .scan_done(scan_done), .row_n(row_n), .col(col),
        .pwr_en(pwr_en), .msg_led(msg_led), .spk_led(spk_led),
        .scan_req(scan_req)
    );

    // Behavioural model: 0 dark, 1 lit, 2 scan
    int       m_code [NCODE];
    int       m_ph, m_row, m_cnt, m_tb;
    bit [7:0] m_col;
    bit       m_msg, m_spk, m_spur;

    function automatic bit pat(input int code, input int t);
        if (code == 0) return 1'b0;
        if (code == 1) return 1'b1;
        if (code <= 8) return bit'((t >> (code + 6)) & 1);
        return bit'(((t >> (code - 1)) & 1) == 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCODE; i++) m_code[i] = 0;
            m_ph = 0; m_row = 0; m_cnt = 0; m_tb = 0;
            m_col = '0; m_msg = 1'b0; m_spk = 1'b0; m_spur = 1'b0;
        end else begin
            m_spur = scan_done && (m_ph != 2);
            if (m_ph == 0 && slow_tick) begin
                if (m_cnt == 1) begin
                    for (int c = 0; c < 8; c++) m_col[c] = pat(m_code[m_row * 8 + c], m_tb);
                    m_msg = pat(m_code[56], m_tb);
                    m_spk = pat(m_code[57], m_tb);
                    m_ph = 1; m_cnt = 0;
                end else m_cnt++;
            end else if (m_ph == 1 && slow_tick) begin
                if (m_cnt == 47) begin
                    m_cnt = 0;
                    if (m_row == 6) m_ph = 2;
                    else begin m_ph = 0; m_row++; end
                end else m_cnt++;
            end else if (m_ph == 2 && scan_done) begin
                m_ph = 0; m_row = 0; m_cnt = 0;
            end
            if (slow_tick) m_tb++;
            if (wr_en && wr_addr < 5'd29) begin
                m_code[2 * wr_addr]     = int'(wr_data[3:0]);
                m_code[2 * wr_addr + 1] = int'(wr_data[7:4]);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [6:0] e_rown;
    logic [7:0] e_col;

    always @(negedge clk) begin
        if (running && !rst) begin
            e_rown = (m_ph == 1) ? (7'h7f & ~(7'h01 << m_row)) : 7'h7f;
            e_col  = (m_ph == 1) ? m_col : 8'h00;
            chk(row_n == e_rown, m_spur ? "R9 scan_done outside scan" : "R2 row drive",
                int'(row_n), int'(e_rown));
            chk(col == e_col, "R3 R7 column pattern", int'(col), int'(e_col));
            chk(pwr_en == (m_ph == 1), "R4 power enable", int'(pwr_en), int'(m_ph == 1));
            chk(scan_req == (m_ph == 2), "R5 scan request", int'(scan_req), int'(m_ph == 2));
            chk(msg_led == m_msg, "R8 message lamp", int'(msg_led), int'(m_msg));
            chk(spk_led == m_spk, "R8 speaker lamp", int'(spk_led), int'(m_spk));
        end
    end

    // Timebase strobe: high every second cycle
    initial forever begin
        @(negedge clk);
        slow_tick = ~slow_tick;
    end

    // Key scanner: answers requests, and also pulses scan_done at odd times (R9)
    initial begin
        int gap;
        gap = 0;
        forever begin
            @(negedge clk);
            if (scan_req) begin
                repeat (3) @(negedge clk);
                scan_done = 1'b1;
                @(negedge clk);
                scan_done = 1'b0;
            end else begin
                gap++;
                if (gap % 97 == 0) begin
                    scan_done = 1'b1;
                    @(negedge clk);
                    scan_done = 1'b0;
                end
            end
        end
    end

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reset_checks();
        chk(row_n == 7'h7f, "R1 reset rows", int'(row_n), 'h7f);
        chk(col == 8'h00, "R1 reset columns", int'(col), 0);
        chk(!pwr_en && !scan_req, "R1 reset power/scan", int'({pwr_en, scan_req}), 0);
        chk(!msg_led && !spk_led, "R1 reset lamps", int'({msg_led, spk_led}), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual %0d cycles expected completion earlier", 150000);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        reset_checks();
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);
        reset_checks();

        // R6: pair layout, lamp register, ignored addresses
        wr(0, 'h10);
        wr(28, 'h01);
        wr(29, 'hff);
        wr(31, 'hff);
        @(posedge scan_req);
        @(posedge pwr_en);
        @(negedge clk);
        chk(row_n == 7'h7e, "R1 R5 first row after scan is row 0", int'(row_n), 'h7e);
        chk(col[1:0] == 2'b10, "R7 codes 0 and 1 on LEDs 0 and 1", int'(col[1:0]), 2);
        chk(msg_led && !spk_led, "R6 lamp codes, addresses 29 and 31 ignored",
            int'({msg_led, spk_led}), 2);

        for (int n = 1; n < 28; n++)
            wr(n, ((n * 7 + 3) % 16) | (((n * 11 + 2) % 16) << 4));
        wr(28, 'h92);
        repeat (3000) @(negedge clk);

        for (int k = 0; k < 40; k++) begin
            repeat (450 + k * 13) @(negedge clk);
            wr((k * 5) % 32, (k * 53 + 17) % 256);
            if (k == 20) begin
                rst = 1'b1;
                repeat (3) @(negedge clk);
                reset_checks();
                rst = 1'b0;
                wr(28, 'h31);
                for (int n = 0; n < 28; n++) wr(n, (n * 29 + 11) % 256);
            end
        end

        repeat (2000) @(negedge clk);
        summary();
        $finish;
    end

endmodule